// File: doc/BRIEF.md
# Partial-Tag Set-Associative Branch Target Buffer

This block guesses where instruction fetch goes next. Every cycle the fetch unit presents the current fetch address. The block looks up one set of a set-associative table and compares all ways of that set at once. If a valid way's short tag matches the address, the stored target address becomes the next fetch address. If no way matches, the next fetch address is the sequential one: the current address plus the instruction size.

Entries are installed only when a branch resolves as taken. A not-taken branch falls through to the sequential address anyway, so it needs no entry. Each entry keeps a valid bit, a truncated tag and a full target address. The truncated tag saves storage. It means that unrelated addresses can alias onto the same entry and produce a false hit. This is acceptable because the block only supplies a guess, and the pipeline behind it checks every prediction.

The lookup path is combinational from the fetch address. Updates are written on the clock edge. Replacement within a set follows a per-set rotating pointer.

Top module: `ptag_btb`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) invalidates every entry and returns every set's replacement pointer to way 0. Any lookup in the cycle after reset misses. An update presented while `rst` is high is discarded.
- R2: A lookup hits when some valid way of the set selected by `lkp_pc[7:2]` holds a tag equal to `lkp_pc[15:8]`. On a hit, `lkp_hit` is 1 and `nxt_pc` equals the stored target.
- R3: On a miss, `lkp_hit` is 0, `lkp_way` is all zeros, and `nxt_pc` equals `lkp_pc + 4`, wrapping modulo 2^32.
- R4: Address bits 31:16 and 1:0 take no part in the match. Two addresses that agree in bits 15:2 reach the same entry and get the same target.
- R5: An update (`upd_en` high) whose set and tag match a valid way overwrites that way's target. The replacement pointer does not move.
- R6: An update that matches no valid way writes the way named by the set's replacement pointer. The pointer then advances 0, 1, 2, 3, 0, so the fifth distinct tag in a set evicts the first.
- R7: When a lookup and an update occur in the same cycle, the lookup sees the table contents from before the update. The written entry becomes visible from the next cycle on.
- R8: An update changes only the set selected by `upd_pc[7:2]`. Entries and the pointer of every other set keep their values.
- R9: `lkp_way` is one-hot on a hit and marks the way that supplied the target. If several ways match, the lowest-numbered one is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lkp_pc | input | 32 | Current fetch address to look up |
| lkp_hit | output | 1 | A valid way of the indexed set matched |
| lkp_way | output | 4 | One-hot marker of the matching way; all zeros on a miss |
| nxt_pc | output | 32 | Predicted next fetch address |
| upd_en | input | 1 | Install or refresh an entry for a resolved taken branch |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Resolved target address of that branch |

## Verification
The hardest cases to reach from the ports are the replacement decisions, because the rotating pointer cannot be observed directly. The stimulus fills one set with more distinct tags than it has ways. It also refreshes an existing tag partway through the fill. The bench then reads back which tags still hit and through which way. This shows whether the refresh left the pointer alone and which entry was evicted.

A random phase keeps updates within two sets and six tags, and varies the upper address bits. This forces frequent aliasing, overwrites and evictions, plus lookups that coincide with updates to the same entry. A behavioural model compares its result with the block's outputs every cycle.

// File: rtl/ptag_btb_pkg.sv
package ptag_btb_pkg;
   // what an update does to the indexed set
   typedef enum logic [1:0] {
      ACT_IDLE    = 2'd0,
      ACT_REFRESH = 2'd1,
      ACT_ALLOC   = 2'd2
   } upd_act_e;
endpackage

// File: rtl/ptag_btb_way.sv
// Storage of one way across all sets: valid, partial tag, target.
module ptag_btb_way #(
   parameter int SETS  = 64,
   parameter int TAG_W = 8,
   parameter int PC_W  = 32,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rd_a_idx,
   output logic             rd_a_vld,
   output logic [TAG_W-1:0] rd_a_tag,
   output logic [PC_W-1:0]  rd_a_tgt,
   input  logic [IDX_W-1:0] rd_b_idx,
   output logic             rd_b_vld,
   output logic [TAG_W-1:0] rd_b_tag,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PC_W-1:0]  wr_tgt
);
   logic             vld_q [SETS];
   logic [TAG_W-1:0] tag_q [SETS];
   logic [PC_W-1:0]  tgt_q [SETS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < SETS; s++) vld_q[s] <= 1'b0;
      end else if (wr_en) begin
         vld_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !rst) begin
         tag_q[wr_idx] <= wr_tag;
         tgt_q[wr_idx] <= wr_tgt;
      end
   end

   assign rd_a_vld = vld_q[rd_a_idx];
   assign rd_a_tag = tag_q[rd_a_idx];
   assign rd_a_tgt = tgt_q[rd_a_idx];
   assign rd_b_vld = vld_q[rd_b_idx];
   assign rd_b_tag = tag_q[rd_b_idx];
endmodule

// File: rtl/ptag_btb_match.sv
// Parallel tag compare across ways with lowest-way priority.
module ptag_btb_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 8
) (
   input  logic [WAYS-1:0]            vld,
   input  logic [WAYS-1:0][TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]           key,
   output logic                       hit,
   output logic [WAYS-1:0]            sel_oh
);
   logic [WAYS-1:0] raw;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign raw[w] = vld[w] && (tags[w] == key);
   end

   always_comb begin
      logic found;
      found  = 1'b0;
      sel_oh = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (raw[w] && !found) begin
            sel_oh[w] = 1'b1;
            found     = 1'b1;
         end
      end
   end

   assign hit = |raw;
endmodule

// File: rtl/ptag_btb_rr.sv
// Per-set rotating replacement pointer.
module ptag_btb_rr #(
   parameter int SETS = 64,
   parameter int WAYS = 4,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   input  logic [IDX_W-1:0] idx,
   output logic [WAY_W-1:0] ptr
);
   logic [WAY_W-1:0] ptr_q [SETS];
   logic [WAY_W-1:0] ptr_nxt;

   assign ptr = ptr_q[idx];

   if ((1 << WAY_W) == WAYS) begin : g_pow2
      assign ptr_nxt = ptr + WAY_W'(1);
   end else begin : g_wrap
      assign ptr_nxt = (ptr == WAY_W'(WAYS - 1)) ? '0 : ptr + WAY_W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
      end else if (adv) begin
         ptr_q[idx] <= ptr_nxt;
      end
   end
endmodule

// File: rtl/ptag_btb.sv
module ptag_btb
   import ptag_btb_pkg::*;
#(
   parameter int WAYS       = 4,
   parameter int SETS       = 64,
   parameter int PC_W       = 32,
   parameter int INST_BYTES = 4,
   parameter int TAG_W      = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [PC_W-1:0] lkp_pc,
   output logic            lkp_hit,
   output logic [WAYS-1:0] lkp_way,
   output logic [PC_W-1:0] nxt_pc,
   input  logic            upd_en,
   input  logic [PC_W-1:0] upd_pc,
   input  logic [PC_W-1:0] upd_target
);
   localparam int IDX_W   = $clog2(SETS);
   localparam int OFS_W   = $clog2(INST_BYTES);
   localparam int WAY_W   = $clog2(WAYS);
   localparam int TAG_LSB = OFS_W + IDX_W;
   localparam int TAG_MSB = TAG_LSB + TAG_W - 1;

   // elaboration-time parameter checks
   if (WAYS < 2) begin : g_chk_ways
      $error("ptag_btb: WAYS must be at least 2");
   end
   if ((1 << IDX_W) != SETS) begin : g_chk_sets
      $error("ptag_btb: SETS must be a power of two");
   end
   if (INST_BYTES < 2 || (1 << OFS_W) != INST_BYTES) begin : g_chk_inst
      $error("ptag_btb: INST_BYTES must be a power of two >= 2");
   end
   if (TAG_MSB >= PC_W - 1 || TAG_W < 1) begin : g_chk_tag
      $error("ptag_btb: tag must be partial and leave upper address bits");
   end

   // address slicing
   logic [IDX_W-1:0] l_idx, u_idx;
   logic [TAG_W-1:0] l_tag, u_tag;
   assign l_idx = lkp_pc[TAG_LSB-1:OFS_W];
   assign l_tag = lkp_pc[TAG_MSB:TAG_LSB];
   assign u_idx = upd_pc[TAG_LSB-1:OFS_W];
   assign u_tag = upd_pc[TAG_MSB:TAG_LSB];

   logic unused_upd_bits;
   assign unused_upd_bits = ^{upd_pc[PC_W-1:TAG_MSB+1], upd_pc[OFS_W-1:0]};

   // per-way storage
   logic [WAYS-1:0]            a_vld, b_vld, wr_oh;
   logic [WAYS-1:0][TAG_W-1:0] a_tag, b_tag;
   logic [WAYS-1:0][PC_W-1:0]  a_tgt;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      ptag_btb_way #(
         .SETS  (SETS),
         .TAG_W (TAG_W),
         .PC_W  (PC_W)
      ) u_way (
         .clk      (clk),
         .rst      (rst),
         .rd_a_idx (l_idx),
         .rd_a_vld (a_vld[w]),
         .rd_a_tag (a_tag[w]),
         .rd_a_tgt (a_tgt[w]),
         .rd_b_idx (u_idx),
         .rd_b_vld (b_vld[w]),
         .rd_b_tag (b_tag[w]),
         .wr_en    (upd_en && wr_oh[w]),
         .wr_idx   (u_idx),
         .wr_tag   (u_tag),
         .wr_tgt   (upd_target)
      );
   end

   // lookup side
   logic            l_hit;
   logic [WAYS-1:0] l_oh;

   ptag_btb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lkp_match (
      .vld    (a_vld),
      .tags   (a_tag),
      .key    (l_tag),
      .hit    (l_hit),
      .sel_oh (l_oh)
   );

   logic [PC_W-1:0] sel_tgt;
   always_comb begin
      sel_tgt = '0;
      for (int w = 0; w < WAYS; w++) begin
         sel_tgt = sel_tgt | (a_tgt[w] & {PC_W{l_oh[w]}});
      end
   end

   assign lkp_hit = l_hit;
   assign lkp_way = l_oh;
   assign nxt_pc  = l_hit ? sel_tgt : lkp_pc + PC_W'(INST_BYTES);

   // update side
   logic            u_hit;
   logic [WAYS-1:0] u_oh;
   logic [WAY_W-1:0] rr_ptr;
   upd_act_e        act;

   ptag_btb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_upd_match (
      .vld    (b_vld),
      .tags   (b_tag),
      .key    (u_tag),
      .hit    (u_hit),
      .sel_oh (u_oh)
   );

   always_comb begin
      if (!upd_en)    act = ACT_IDLE;
      else if (u_hit) act = ACT_REFRESH;
      else            act = ACT_ALLOC;
   end

   always_comb begin
      case (act)
         ACT_REFRESH: wr_oh = u_oh;
         ACT_ALLOC:   wr_oh = WAYS'(1) << rr_ptr;
         default:     wr_oh = '0;
      endcase
   end

   ptag_btb_rr #(.SETS(SETS), .WAYS(WAYS)) u_rr (
      .clk (clk),
      .rst (rst),
      .adv (act == ACT_ALLOC),
      .idx (u_idx),
      .ptr (rr_ptr)
   );
endmodule

// File: rtl/ptag_btb_chk.sv
module ptag_btb_chk #(
   parameter int WAYS       = 4,
   parameter int PC_W       = 32,
   parameter int INST_BYTES = 4
) (
   input logic            clk,
   input logic            rst,
   input logic [PC_W-1:0] lkp_pc,
   input logic            lkp_hit,
   input logic [WAYS-1:0] lkp_way,
   input logic [PC_W-1:0] nxt_pc,
   input logic            upd_en,
   input logic [PC_W-1:0] upd_pc,
   input logic [PC_W-1:0] upd_target
);
   AST_RESET_MISS: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !lkp_hit); // R1

   AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
      !lkp_hit |-> (nxt_pc == lkp_pc + PC_W'(INST_BYTES)) && (lkp_way == '0)); // R3

   AST_UPDATE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
      (upd_en && !rst) |=> ((lkp_pc != $past(upd_pc)) ||
                            (lkp_hit && nxt_pc == $past(upd_target)))); // R7

   AST_WAY_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(lkp_way) && ((lkp_way != '0) == lkp_hit)); // R9
endmodule

bind ptag_btb ptag_btb_chk #(
   .WAYS       (WAYS),
   .PC_W       (PC_W),
   .INST_BYTES (INST_BYTES)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .lkp_pc     (lkp_pc),
   .lkp_hit    (lkp_hit),
   .lkp_way    (lkp_way),
   .nxt_pc     (nxt_pc),
   .upd_en     (upd_en),
   .upd_pc     (upd_pc),
   .upd_target (upd_target)
);

// File: tb/ptag_btb_tb.sv
module ptag_btb_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] lkp_pc;
   logic        lkp_hit;
   logic [3:0]  lkp_way;
   logic [31:0] nxt_pc;
   logic        upd_en;
   logic [31:0] upd_pc;
   logic [31:0] upd_target;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ptag_btb u_dut (
      .clk        (clk),
      .rst        (rst),
      .lkp_pc     (lkp_pc),
      .lkp_hit    (lkp_hit),
      .lkp_way    (lkp_way),
      .nxt_pc     (nxt_pc),
      .upd_en     (upd_en),
      .upd_pc     (upd_pc),
      .upd_target (upd_target)
   );

   // behavioural reference: 64 sets x 4 ways
   bit          m_v   [64][4];
   int unsigned m_tag [64][4];
   int unsigned m_tgt [64][4];
   int          m_ptr [64];

   function automatic int unsigned set_of(input logic [31:0] pc);
      return (pc >> 2) % 64;
   endfunction
   function automatic int unsigned tag_of(input logic [31:0] pc);
      return (pc >> 8) % 256;
   endfunction
   function automatic logic [31:0] mkpc(input int unsigned hi, input int unsigned tg,
                                        input int unsigned st, input int unsigned lo);
      return (hi << 16) | ((tg % 256) << 8) | ((st % 64) << 2) | (lo % 4);
   endfunction

   function automatic int model_way(input logic [31:0] pc);
      for (int w = 0; w < 4; w++)
         if (m_v[set_of(pc)][w] && m_tag[set_of(pc)][w] == tag_of(pc)) return w;
      return -1;
   endfunction

   task automatic model_clock(input logic r, input logic ue, input logic [31:0] up,
                              input logic [31:0] ut);
      if (r) begin
         for (int s = 0; s < 64; s++) begin
            m_ptr[s] = 0;
            for (int w = 0; w < 4; w++) m_v[s][w] = 0;
         end
      end else if (ue) begin
         int w;
         int unsigned s;
         s = set_of(up);
         w = model_way(up);
         if (w < 0) begin
            w = m_ptr[s];
            m_ptr[s] = (m_ptr[s] + 1) % 4;
         end
         m_v[s][w]   = 1;
         m_tag[s][w] = tag_of(up);
         m_tgt[s][w] = ut;
      end
   endtask

   task automatic compare_model(input string req);
      int w;
      logic        e_hit;
      logic [3:0]  e_way;
      logic [31:0] e_nxt;
      w = model_way(lkp_pc);
      e_hit = (w >= 0);
      e_way = e_hit ? 4'(1 << w) : 4'b0000;
      e_nxt = e_hit ? m_tgt[set_of(lkp_pc)][w] : lkp_pc + 32'd4;
      checks++;
      if (lkp_hit !== e_hit || lkp_way !== e_way || nxt_pc !== e_nxt) begin
         errors++;
         $display("FAIL %s model pc=%h: got hit=%b way=%b nxt=%h, expected hit=%b way=%b nxt=%h",
                  req, lkp_pc, lkp_hit, lkp_way, nxt_pc, e_hit, e_way, e_nxt);
      end
   endtask

   task automatic step(input logic r, input logic [31:0] pc, input logic ue,
                       input logic [31:0] up, input logic [31:0] ut, input string req);
      @(negedge clk);
      rst = r; lkp_pc = pc; upd_en = ue; upd_pc = up; upd_target = ut;
      #1;
      compare_model(req);
      @(posedge clk);
      model_clock(r, ue, up, ut);
   endtask

   // lookup with explicit expected values in addition to the model
   task automatic expect_lkp(input logic [31:0] pc, input logic e_hit, input logic [31:0] e_nxt,
                             input logic [3:0] e_way, input string req);
      @(negedge clk);
      rst = 0; lkp_pc = pc; upd_en = 0;
      #1;
      compare_model(req);
      checks++;
      if (lkp_hit !== e_hit || nxt_pc !== e_nxt || lkp_way !== e_way) begin
         errors++;
         $display("FAIL %s pc=%h: got hit=%b nxt=%h way=%b, expected hit=%b nxt=%h way=%b",
                  req, pc, lkp_hit, nxt_pc, lkp_way, e_hit, e_nxt, e_way);
      end
      @(posedge clk);
   endtask

   task automatic upd(input logic [31:0] up, input logic [31:0] ut, input string req);
      step(1'b0, up, 1'b1, up, ut, req);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst = 1; lkp_pc = 0; upd_en = 0; upd_pc = 0; upd_target = 0;
      for (int i = 0; i < 3; i++) step(1'b1, 32'h0, 1'b1, mkpc(0, 1, 1, 0), 32'h1, "R1");

      // R1: everything misses after reset, update during reset discarded
      expect_lkp(mkpc(0, 1, 1, 0), 0, mkpc(0, 1, 1, 0) + 4, 4'b0000, "R1");
      // R3: wrap of sequential address
      expect_lkp(32'hFFFF_FFFC, 0, 32'h0000_0000, 4'b0000, "R3");

      // R7: same-cycle lookup and install sees old contents
      step(1'b0, mkpc(0, 8'h11, 5, 0), 1'b1, mkpc(0, 8'h11, 5, 0), 32'h0000_1000, "R7");
      // R2: hit next cycle, way 0
      expect_lkp(mkpc(0, 8'h11, 5, 0), 1, 32'h0000_1000, 4'b0001, "R2");
      upd(mkpc(0, 8'h22, 5, 0), 32'h0000_2200, "R6");
      // R4: upper bits and low bits ignored
      expect_lkp(mkpc(16'hABCD, 8'h11, 5, 3), 1, 32'h0000_1000, 4'b0001, "R4");
      expect_lkp(mkpc(16'h1234, 8'h22, 5, 1), 1, 32'h0000_2200, 4'b0010, "R4");
      // R5: refresh keeps way, pointer unmoved
      upd(mkpc(16'h7777, 8'h11, 5, 0), 32'h0000_3000, "R5");
      expect_lkp(mkpc(0, 8'h11, 5, 0), 1, 32'h0000_3000, 4'b0001, "R5");
      upd(mkpc(0, 8'h33, 5, 0), 32'h0000_3300, "R6");
      upd(mkpc(0, 8'h44, 5, 0), 32'h0000_4400, "R6");
      expect_lkp(mkpc(0, 8'h44, 5, 0), 1, 32'h0000_4400, 4'b1000, "R6");
      // R6: fifth distinct tag evicts way 0 (tag 0x11)
      upd(mkpc(0, 8'h55, 5, 0), 32'h0000_5500, "R6");
      expect_lkp(mkpc(0, 8'h11, 5, 0), 0, mkpc(0, 8'h11, 5, 0) + 4, 4'b0000, "R6");
      expect_lkp(mkpc(0, 8'h55, 5, 0), 1, 32'h0000_5500, 4'b0001, "R6");
      expect_lkp(mkpc(0, 8'h22, 5, 0), 1, 32'h0000_2200, 4'b0010, "R5");
      // R8: neighbouring set untouched, then filled without disturbing set 5
      expect_lkp(mkpc(0, 8'h22, 6, 0), 0, mkpc(0, 8'h22, 6, 0) + 4, 4'b0000, "R8");
      for (int i = 0; i < 6; i++) upd(mkpc(0, 8'h60 + i, 6, 0), 32'h0000_6000 + i, "R8");
      expect_lkp(mkpc(0, 8'h33, 5, 0), 1, 32'h0000_3300, 4'b0100, "R8");
      upd(mkpc(0, 8'h66, 5, 0), 32'h0000_6600, "R8");
      expect_lkp(mkpc(0, 8'h66, 5, 0), 1, 32'h0000_6600, 4'b0010, "R8");

      // random phase: heavy conflict in sets 9 and 10, aliasing upper bits
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] a, b;
         a = mkpc($urandom % 4, $urandom % 6, 9 + $urandom % 2, $urandom % 4);
         b = ($urandom % 3 == 0) ? a : mkpc($urandom % 4, $urandom % 6, 9 + $urandom % 2, 0);
         step(1'b0, a, ($urandom % 2) == 1, b, $urandom, "R9");
      end

      // R1: reset mid-run clears everything
      step(1'b1, 32'h0, 1'b0, 32'h0, 32'h0, "R1");
      expect_lkp(mkpc(0, 8'h55, 5, 0), 0, mkpc(0, 8'h55, 5, 0) + 4, 4'b0000, "R1");
      upd(mkpc(0, 8'h77, 5, 0), 32'h0000_7700, "R1");
      expect_lkp(mkpc(0, 8'h77, 5, 0), 1, 32'h0000_7700, 4'b0001, "R1");

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule